// File: doc/BRIEF.md
# Serial Bit, Word and Frame Timing Generator

This block produces the timing backbone of a synchronous serial audio-style port. A fast reference enable, qualified against the system clock, feeds a programmable divider that makes the bit clock. Each bit boundary (falling bit-clock edge) steps a bit counter. When the bit counter reaches the programmed word length it raises a one-cycle word strobe, and that strobe steps a word counter. When the word counter completes the programmed number of words it raises a one-cycle frame strobe. In master mode the block drives the bit-clock, frame-sync and (optionally) master-clock pins. In slave mode the bit clock and frame sync are taken from input pins instead, after two-flop synchronizers.

The divider, word length and words-per-frame settings are held in shadow copies that reload only at a frame boundary, so a change made mid-frame never shortens or stretches the frame in progress. Serial data shifting is handled elsewhere. This block only provides the strobes that such logic needs.

Top module: `serial_timing_gen`

## Requirements
- R1: The 3-bit length code selects bits per word as 0→8, 1→10, 2→12, 3→16, 4→18, 5→20, 6→22, 7→24. A word strobe fires on the bit boundary that ends the last bit of each word, so a frame of W words holds W times that many bit-clock falling edges.
- R2: `words_cfg` holds the words per frame minus one. The frame strobe fires once per frame, in the same cycle as the word strobe of the last word, and each frame carries `words_cfg`+1 word strobes.
- R3: In master mode `fs_o` is high for exactly one bit period per frame, starting with the first bit of word 0 (it rises in the cycle the bit clock falls).
- R4: In master mode the bit clock spends (D+1) reference ticks low and then (D+1) reference ticks high, where D is the effective divider. A bit boundary is the falling edge.
- R5: A divider setting below 2 is treated as 2, so the bit-clock period is never shorter than 6 system-clock cycles (each phase lasts at least 3 cycles).
- R6: With master mode and `mclk_en` both set, `mclk_o` toggles on every reference tick, so one frame holds (D+1)·bits·words master-clock periods. Otherwise `mclk_o` stays low.
- R7: In slave mode `bclk_o`, `fs_o` and `mclk_o` stay low. Bit boundaries come from falling edges of the synchronized `ext_bclk`, and word strobes occur once per word length of external bit periods.
- R8: In slave mode a high synchronized `ext_fs` at a bit boundary restarts counting at bit 0 of word 0. When the external frame length matches the configuration, every frame strobe follows an `ext_fs` rise within a few cycles.
- R9: New divider, length and word-count settings take effect only at a frame boundary. The frame in progress keeps its old length.
- R10: While reset is held, `bclk_o`, `mclk_o`, `word_done` and `frame_done` are low. `fs_o` is high in master mode (a frame starts at reset) and low in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | Reference clock enable, one tick per cycle it is high |
| master_mode | input | 1 | 1: generate bit clock and frame sync; 0: take them from pins |
| mclk_en | input | 1 | Master-clock output enable (master mode only) |
| div_cfg | input | DIV_W | Bit-clock half-period in reference ticks, minus one |
| wl_code | input | 3 | Word length code |
| words_cfg | input | WCNT_W | Words per frame minus one |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fs | input | 1 | External frame sync (slave mode) |
| bclk_o | output | 1 | Bit-clock pin |
| fs_o | output | 1 | Frame-sync pin |
| mclk_o | output | 1 | Master-clock pin |
| word_done | output | 1 | One-cycle strobe at the end of each word |
| frame_done | output | 1 | One-cycle strobe at the end of each frame |

## Verification
The bench builds the block with its default parameters: a 4-bit divider field, a 3-bit words-per-frame field and a divider floor of 2. It drives divider values 0 to 5, all eight length codes and one to three words per frame. It also uses reference enables that arrive every cycle or every other cycle. This lets it reach the clamped-divider region, the longest 24-bit words and a mid-frame reprogramming whose effect must be deferred. In slave mode it uses external bit periods of 6 to 10 system cycles with a random starting offset, which exercises the resynchronization.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int BIT_W = 5;

  // Bits per word for each 3-bit length code.
  function automatic logic [BIT_W-1:0] wl_bits(input logic [2:0] code);
    logic [BIT_W-1:0] r;
    case (code)
      3'd0: r = 5'd8;
      3'd1: r = 5'd10;
      3'd2: r = 5'd12;
      3'd3: r = 5'd16;
      3'd4: r = 5'd18;
      3'd5: r = 5'd20;
      3'd6: r = 5'd22;
      default: r = 5'd24;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sts_bitclk.sv
module sts_bitclk #(
  parameter int DIV_W   = 4,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             master,
  input  logic [DIV_W-1:0] div_q,
  input  logic             ext_bclk,
  input  logic             ext_fs,
  output logic             bclk_o,
  output logic             bit_tick,
  output logic             fs_ext
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic [2:0]       bsync_q;
  logic [1:0]       fsync_q;
  logic [DIV_W-1:0] div_eff;
  logic             half_end;

  assign div_eff  = (div_q < FLOOR) ? FLOOR : div_q;
  assign half_end = ref_en && (cnt_q >= div_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      bsync_q <= '0;
      fsync_q <= '0;
    end else begin
      bsync_q <= {bsync_q[1:0], ext_bclk};
      fsync_q <= {fsync_q[0], ext_fs};
      if (!master) begin
        cnt_q  <= '0;
        bclk_q <= 1'b0;
      end else if (half_end) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else if (ref_en) begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  // Bit boundary: falling edge of the generated or synchronized bit clock.
  assign bit_tick = master ? (half_end && bclk_q) : (bsync_q[2] && !bsync_q[1]);
  assign fs_ext   = !master && fsync_q[1];
  assign bclk_o   = bclk_q;
endmodule

// File: rtl/sts_frame_ctr.sv
module sts_frame_ctr
  import sts_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int WCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              resync,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [2:0]        wl_code,
  input  logic [WCNT_W-1:0] words_cfg,
  output logic [DIV_W-1:0]  div_q,
  output logic              word_done,
  output logic              frame_done,
  output logic              frame_start
);
  logic [2:0]        wl_q;
  logic [WCNT_W-1:0] nw_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WCNT_W-1:0] word_q;
  logic              last_bit;

  assign last_bit    = (bit_q == BIT_W'(wl_bits(wl_q) - 5'd1));
  assign word_done   = bit_tick && last_bit;
  assign frame_done  = word_done && (word_q == nw_q);
  assign frame_start = (bit_q == '0) && (word_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= div_cfg;
      wl_q   <= wl_code;
      nw_q   <= words_cfg;
      bit_q  <= '0;
      word_q <= '0;
    end else if (bit_tick) begin
      if (resync) begin
        bit_q  <= '0;
        word_q <= '0;
      end else if (last_bit) begin
        bit_q  <= '0;
        word_q <= frame_done ? '0 : word_q + WCNT_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
      if (frame_done) begin
        div_q <= div_cfg;
        wl_q  <= wl_code;
        nw_q  <= words_cfg;
      end
    end
  end
endmodule

// File: rtl/sts_mclk.sv
module sts_mclk (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic enable,
  output logic mclk_o
);
  logic mclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) mclk_q <= 1'b0;
    else if (ref_en)       mclk_q <= ~mclk_q;
  end

  assign mclk_o = mclk_q;
endmodule

// File: rtl/serial_timing_gen.sv
module serial_timing_gen #(
  parameter int DIV_W   = 4,
  parameter int WCNT_W  = 3,
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              master_mode,
  input  logic              mclk_en,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [2:0]        wl_code,
  input  logic [WCNT_W-1:0] words_cfg,
  input  logic              ext_bclk,
  input  logic              ext_fs,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              mclk_o,
  output logic              word_done,
  output logic              frame_done
);
  logic [DIV_W-1:0] div_q;
  logic             bit_tick;
  logic             fs_ext;
  logic             frame_start;
  logic             mclk_on;

  sts_bitclk #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .master   (master_mode),
    .div_q    (div_q),
    .ext_bclk (ext_bclk),
    .ext_fs   (ext_fs),
    .bclk_o   (bclk_o),
    .bit_tick (bit_tick),
    .fs_ext   (fs_ext)
  );

  sts_frame_ctr #(.DIV_W(DIV_W), .WCNT_W(WCNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .resync      (fs_ext),
    .div_cfg     (div_cfg),
    .wl_code     (wl_code),
    .words_cfg   (words_cfg),
    .div_q       (div_q),
    .word_done   (word_done),
    .frame_done  (frame_done),
    .frame_start (frame_start)
  );

  assign mclk_on = master_mode && mclk_en;

  sts_mclk u_mclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_en (ref_en),
    .enable (mclk_on),
    .mclk_o (mclk_o)
  );

  assign fs_o = master_mode && frame_start;
endmodule

// File: rtl/sts_checker.sv
module sts_checker (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic mclk_en,
  input logic bclk_o,
  input logic fs_o,
  input logic mclk_o,
  input logic word_done,
  input logic frame_done,
  input logic bit_tick
);
  // R1: a word ends only on a bit boundary
  p_word_on_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> bit_tick);

  // R1: word strobe lasts a single cycle
  p_word_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R2: frame end coincides with a word end
  p_frame_on_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> word_done);

  // R3: frame sync starts together with a falling bit clock
  p_fs_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> $fell(bclk_o));

  // R5: each bit-clock phase lasts at least three cycles
  p_bclk_high_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_o) |-> ($past(bclk_o, 2) && $past(bclk_o, 3)));

  p_bclk_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> (!$past(bclk_o, 2) && !$past(bclk_o, 3)));

  // R6: master clock is silenced when not enabled
  p_mclk_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |=> !mclk_o);

  // R7: slave mode leaves the clock pins quiet
  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |=> (!bclk_o && !mclk_o));
endmodule

bind serial_timing_gen sts_checker u_sts_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_mode (master_mode),
  .mclk_en     (mclk_en),
  .bclk_o      (bclk_o),
  .fs_o        (fs_o),
  .mclk_o      (mclk_o),
  .word_done   (word_done),
  .frame_done  (frame_done),
  .bit_tick    (bit_tick)
);

// File: tb/tb_serial_timing_gen.sv
module tb_serial_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W  = 4;
  localparam int WCNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic master_mode = 1'b1;
  logic mclk_en = 1'b0;
  logic [DIV_W-1:0] div_cfg = '0;
  logic [2:0] wl_code = '0;
  logic [WCNT_W-1:0] words_cfg = '0;
  logic ext_bclk = 1'b0;
  logic ext_fs = 1'b0;
  logic bclk_o, fs_o, mclk_o, word_done, frame_done;

  int n_cmp = 0;
  int n_bad = 0;
  int per = 1;
  bit s_on = 1'b0;
  int s_half = 3;
  int s_len = 8;
  int s_bit = 0;
  int seed_v;

  serial_timing_gen #(.DIV_W(DIV_W), .WCNT_W(WCNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .master_mode(master_mode),
    .mclk_en(mclk_en), .div_cfg(div_cfg), .wl_code(wl_code),
    .words_cfg(words_cfg), .ext_bclk(ext_bclk), .ext_fs(ext_fs),
    .bclk_o(bclk_o), .fs_o(fs_o), .mclk_o(mclk_o),
    .word_done(word_done), .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Stimulus generators: periodic reference enable and external slave clocks.
  initial begin
    int pc = 0;
    int hc = 0;
    forever begin
      @(posedge clk);
      #1;
      ref_en = (pc == 0);
      pc = (pc + 1 >= per) ? 0 : pc + 1;
      if (!s_on) begin
        ext_bclk = 1'b0;
        ext_fs = 1'b0;
        hc = 0;
      end else begin
        hc++;
        if (hc >= s_half) begin
          hc = 0;
          ext_bclk = ~ext_bclk;
          if (!ext_bclk) begin
            s_bit = (s_bit + 1) % s_len;
            ext_fs = (s_bit == 0);
          end
        end
      end
    end
  end

  function automatic int exp_wl(input int code);
    return (code < 3) ? 8 + 2 * code : 10 + 2 * code;
  endfunction

  function automatic int exp_de(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int exp_frame_cyc(input int d, input int code, input int n, input int p);
    return 2 * (exp_de(d) + 1) * exp_wl(code) * (n + 1) * p;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit m);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "bclk in reset", int'(bclk_o), 0);
    chk("R10", "mclk in reset", int'(mclk_o), 0);
    chk("R10", "strobes in reset", int'(word_done) + int'(frame_done), 0);
    chk("R10", "fs in reset", int'(fs_o), m ? 1 : 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_fd();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!frame_done && t < 40000);
    if (t >= 40000) chk("R2", "frame strobe timeout", 0, 1);
  endtask

  // Called right after a sampled frame strobe; runs to the next one.
  task automatic measure(input int chg_at, input int nd, input int nc, input int nn,
                         output int cyc, output int words, output int fs_hi,
                         output int mrise, output int bfall);
    logic pm, pb;
    pm = mclk_o; pb = bclk_o;
    cyc = 0; words = 0; fs_hi = 0; mrise = 0; bfall = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (chg_at != 0 && cyc == chg_at) begin
        div_cfg = DIV_W'(nd);
        wl_code = 3'(nc);
        words_cfg = WCNT_W'(nn);
      end
      words += int'(word_done);
      fs_hi += int'(fs_o);
      if (mclk_o && !pm) mrise++;
      if (!bclk_o && pb) bfall++;
      pm = mclk_o; pb = bclk_o;
    end while (!frame_done && cyc < 40000);
  endtask

  task automatic run_master(input int d, input int c, input int n, input int p, input bit mon);
    int cyc, words, fs_hi, mrise, bfall;
    per = p; s_on = 1'b0;
    master_mode = 1'b1; mclk_en = mon;
    div_cfg = DIV_W'(d); wl_code = 3'(c); words_cfg = WCNT_W'(n);
    do_reset(1'b1);
    wait_fd();
    measure(0, 0, 0, 0, cyc, words, fs_hi, mrise, bfall);
    chk((d < 2) ? "R5" : "R4", "frame cycles", cyc, exp_frame_cyc(d, c, n, p));
    chk("R2", "words per frame", words, n + 1);
    chk("R1", "bits per frame", bfall, exp_wl(c) * (n + 1));
    chk("R3", "fs high cycles", fs_hi, 2 * (exp_de(d) + 1) * p);
    chk("R6", "mclk periods per frame", mrise,
        mon ? (exp_de(d) + 1) * exp_wl(c) * (n + 1) : 0);
  endtask

  task automatic run_slave(input int c, input int n, input int h, input int off);
    int t = 0, rises = 0, since = 100, fd_cnt = 0, bad = 0, quiet = 0;
    int wd_last = -1, wd_bad = 0;
    logic pfs = 1'b0;
    per = 1; s_on = 1'b0;
    master_mode = 1'b0; mclk_en = 1'b1;
    div_cfg = '0; wl_code = 3'(c); words_cfg = WCNT_W'(n);
    s_half = h; s_len = exp_wl(c) * (n + 1); s_bit = off % s_len;
    do_reset(1'b0);
    s_on = 1'b1;
    while (!(rises >= 5 && since >= 10) && t < 60000) begin
      @(negedge clk);
      t++;
      if (bclk_o || fs_o || mclk_o) quiet++;
      if (ext_fs && !pfs) begin rises++; since = 0; end
      else since++;
      pfs = ext_fs;
      if (rises >= 2) begin
        if (frame_done) begin
          fd_cnt++;
          if (since < 1 || since > 6) bad++;
        end
        if (word_done) begin
          if (wd_last >= 0 && (t - wd_last) != 2 * h * exp_wl(c)) wd_bad++;
          wd_last = t;
        end
      end
    end
    s_on = 1'b0;
    chk("R7", "slave pins active cycles", quiet, 0);
    chk("R7", "slave word spacing errors", wd_bad, 0);
    chk("R8", "frame strobes off ext sync", bad, 0);
    chk("R8", "frame strobe count", fd_cnt, 4);
  endtask

  task automatic run_defer();
    int cyc, words, fs_hi, mrise, bfall;
    per = 1; s_on = 1'b0;
    master_mode = 1'b1; mclk_en = 1'b1;
    div_cfg = DIV_W'(2); wl_code = 3'd1; words_cfg = WCNT_W'(1);
    do_reset(1'b1);
    wait_fd();
    measure(15, 4, 5, 0, cyc, words, fs_hi, mrise, bfall);
    chk("R9", "frame after mid-frame change", cyc, exp_frame_cyc(2, 1, 1, 1));
    chk("R9", "words after mid-frame change", words, 2);
    measure(0, 0, 0, 0, cyc, words, fs_hi, mrise, bfall);
    chk("R9", "frame with new settings", cyc, exp_frame_cyc(4, 5, 0, 1));
    chk("R9", "bits with new settings", bfall, exp_wl(5));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd4711);
    // Directed corners
    run_master(0, 0, 0, 1, 1'b1);   // clamped divider, shortest word
    run_master(1, 7, 1, 1, 1'b0);   // clamped divider, longest word, mclk off
    run_master(3, 3, 2, 2, 1'b1);   // sparse reference ticks
    run_master(5, 4, 0, 1, 1'b1);
    run_defer();
    // Random master runs
    for (int i = 0; i < 6; i++) begin
      run_master(int'($urandom_range(5, 0)), int'($urandom_range(7, 0)),
                 int'($urandom_range(2, 0)), int'($urandom_range(2, 1)),
                 1'($urandom_range(1, 0)));
    end
    // Slave runs
    run_slave(0, 1, 3, 5);
    run_slave(7, 2, 5, 17);
    for (int i = 0; i < 2; i++) begin
      run_slave(int'($urandom_range(7, 0)), int'($urandom_range(2, 0)),
                int'($urandom_range(5, 3)), int'($urandom_range(40, 0)));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule